// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Burst Fill

This block is a read-only instruction cache that sits between a fetch unit and an external memory bus that supports bursts. The fetch unit presents a word-aligned 32-bit address with a request strobe. On a hit, the cache returns the matching 32-bit instruction on the next cycle. On a miss, the cache issues one four-word burst read for the whole line and writes each returned word into the line as it arrives. The word the fetch unit asked for is passed straight from its bus beat to the fetch port in the same cycle that beat is written into the line, so the array is never read a second time.

The default geometry holds 512 bytes of data in 32 lines of four 32-bit words. Address bits [3:2] pick the word, bits [8:4] pick the line and bits [31:9] form the tag. While a fill is in progress the fetch side sees `fetch_ready` low and holds its request. A one-cycle invalidate input clears the whole cache.

Top module: `fetch_icache`

## Requirements
- R1: After reset every line is invalid, `fetch_valid` and `mem_req` are low and `fetch_ready` is high, so the first fetch to any address misses.
- R2: A fetch accepted (`fetch_req` and `fetch_ready` both high at a clock edge) that misses raises `mem_req` on the next cycle. `mem_req` holds high, with a constant `mem_addr` equal to the line base, until a cycle in which `mem_gnt` is high.
- R3: An accepted fetch that hits raises `fetch_valid` for one cycle on the next cycle, with the stored word on `fetch_data`, and issues no bus request.
- R4: On a miss, `fetch_valid` rises in the cycle right after the beat whose position in the line equals the address's word field (bits [3:2]). `fetch_data` then carries that beat's data. Each accepted fetch produces exactly one `fetch_valid` pulse.
- R5: Beats are written into word positions 0, 1, 2, 3 of the line in arrival order, so later hits to any word of the line return the data of the matching beat.
- R6: Cycles without `mem_rvalid` between beats do not advance the fill position. Data order and forwarding stay correct under such gaps.
- R7: `fetch_ready` stays low from the cycle after a missing fetch is accepted until the fourth beat has been taken. It is high in the cycle right after the fourth beat. The line becomes valid at that point.
- R8: When `inv_all` is high, `fetch_ready` is low in that cycle and every line becomes invalid, so previously filled lines miss afterwards.
- R9: If `inv_all` is high at any time during a fill, the line being filled is not marked valid when the fill completes. The requested word is still forwarded.
- R10: Two addresses with the same line index but different tags replace each other, and each access to the evicted one misses again.
- R11: `mem_addr` bits [3:0] are zero whenever `mem_req` is high, and `mem_req` is low in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Invalidate every line this cycle |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | 32 | Word-aligned instruction address |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| fetch_valid | output | 1 | Instruction on `fetch_data` is valid |
| fetch_data | output | 32 | Returned instruction word |
| mem_req | output | 1 | Burst read request for one line |
| mem_addr | output | 32 | Line base address of the burst |
| mem_gnt | input | 1 | Memory side accepts the burst request |
| mem_rvalid | input | 1 | A burst beat is present on `mem_rdata` |
| mem_rdata | input | 32 | Burst beat data |

## Verification
The hardest case to reach from the ports is an invalidate that lands in the middle of a fill. That fill must still forward its word, yet its line must stay invalid afterwards. The bench memory model can raise `inv_all` in the same cycle as a chosen beat. The bench then fetches the same address twice and expects a miss followed by a hit. The bench also checks the exact cycle of forwarding and of `fetch_ready` returning. It does this inside the memory model at the cycle after each beat, with grant delays and gaps between beats varied from fetch to fetch.

// File: rtl/icache_pkg.sv
// Package icache_pkg
// Shared types for the instruction cache: the fill controller state encoding.
// Assumes nothing beyond being compiled before the modules that import it.
package icache_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,   // ready for lookups
        FILL_REQ  = 2'd1,   // burst request raised, waiting for grant
        FILL_BEAT = 2'd2    // collecting burst beats
    } fill_state_t;

endpackage

// File: rtl/icache_tag_store.sv
// Module icache_tag_store
// Holds one tag and one valid bit per line. Lookup is combinational on
// rd_idx. A line is installed (tag written, valid set) through the write
// port. inv_all clears every valid bit in one cycle and wins over a write
// in the same cycle. Assumes the tag array needs no reset because valid
// bits gate every use of it.
module icache_tag_store #(
    parameter int LINES = 32,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_q;

    // Per-line valid bit: reset, global invalidate, or set on install.
    for (genvar g = 0; g < LINES; g++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n || inv_all) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end
    end

    // Tag write on install.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    // Combinational lookup port.
    always_comb begin
        rd_tag   = tag_mem[rd_idx];
        rd_valid = valid_q[rd_idx];
    end

endmodule

// File: rtl/icache_data_array.sv
// Module icache_data_array
// Instruction word storage organised as LINES x LINE_WORDS words, with one
// write port (used by burst beats) and one combinational read port (used by
// hits). Assumes read and write never target the same word in one cycle,
// because lookups are blocked while a fill is running.
module icache_data_array #(
    parameter int LINES      = 32,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WORD_W = $clog2(LINE_WORDS),
    localparam int DEPTH  = LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Beat write into the addressed word of the addressed line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_idx, wr_word}] <= wr_data;
        end
    end

    // Combinational read for the hit path.
    always_comb begin
        rd_data = mem[{rd_idx, rd_word}];
    end

endmodule

// File: rtl/icache_fill_ctrl.sv
// Module icache_fill_ctrl
// Line-fill sequencer. On start it raises the burst request and holds it
// until granted. It then counts LINE_WORDS beats, advancing only on beats
// that carry data. On the final beat it installs the line unless an
// invalidate was seen at any point during the fill. Assumes the memory
// side returns beats in ascending word order starting at the line base.
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    localparam int WORD_W = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              inv_all,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic              busy,
    output logic              beat_we,
    output logic [WORD_W-1:0] beat_word,
    output logic              install
);

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);

    fill_state_t       state_q;
    fill_state_t       state_d;
    logic [WORD_W-1:0] cnt_q;
    logic              poison_q;
    logic              last_beat;

    assign last_beat = (state_q == FILL_BEAT) && mem_rvalid && (cnt_q == LAST_WORD);

    // Next-state selection for the fill sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: if (start)     state_d = FILL_REQ;
            FILL_REQ:  if (mem_gnt)   state_d = FILL_BEAT;
            FILL_BEAT: if (last_beat) state_d = FILL_IDLE;
            default:                  state_d = FILL_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Beat counter: cleared on grant, advanced only on beats with data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == FILL_REQ) begin
            cnt_q <= '0;
        end else if (state_q == FILL_BEAT && mem_rvalid) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Poison flag: an invalidate during a fill keeps the line invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poison_q <= 1'b0;
        end else if (state_q == FILL_IDLE) begin
            poison_q <= 1'b0;
        end else if (inv_all) begin
            poison_q <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        mem_req   = (state_q == FILL_REQ);
        busy      = (state_q != FILL_IDLE);
        beat_we   = (state_q == FILL_BEAT) && mem_rvalid;
        beat_word = cnt_q;
        install   = last_beat && !poison_q && !inv_all;
    end

endmodule

// File: rtl/fetch_icache.sv
// Module fetch_icache
// Top of the direct-mapped instruction cache. A fetch is accepted when the
// cache is idle and not being invalidated. A hit answers on the next cycle
// from the data array. A miss latches the line coordinates and starts a
// burst fill, and the requested word is forwarded from its beat through
// the same output register. Assumes fetch addresses are word aligned
// (bits below the word field are ignored).
module fetch_icache #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 512,
    parameter int LINE_WORDS  = 4,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int LINE_BYTES = WORD_BYTES * LINE_WORDS,
    localparam int LINES      = CACHE_BYTES / LINE_BYTES,
    localparam int BOFF_W     = $clog2(WORD_BYTES),
    localparam int WORD_W     = $clog2(LINE_WORDS),
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - IDX_W - WORD_W - BOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int WORD_LSB = BOFF_W;
    localparam int IDX_LSB  = BOFF_W + WORD_W;
    localparam int TAG_LSB  = IDX_LSB + IDX_W;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WORD_W-1:0] req_word;
    logic [TAG_W-1:0]  miss_tag_q;
    logic [IDX_W-1:0]  miss_idx_q;
    logic [WORD_W-1:0] miss_word_q;

    logic [TAG_W-1:0]  look_tag;
    logic              look_valid;
    logic [DATA_W-1:0] look_data;

    logic accept;
    logic hit;
    logic miss;
    logic busy;
    logic beat_we;
    logic [WORD_W-1:0] beat_word;
    logic install;
    logic forward;

    // Split the fetch address into tag, line index and word fields.
    always_comb begin
        req_tag  = fetch_addr[ADDR_W-1:TAG_LSB];
        req_idx  = fetch_addr[TAG_LSB-1:IDX_LSB];
        req_word = fetch_addr[IDX_LSB-1:WORD_LSB];
    end

    // Acceptance and hit/miss classification of the current fetch.
    always_comb begin
        fetch_ready = !busy && !inv_all;
        accept      = fetch_req && fetch_ready;
        hit         = accept && look_valid && (look_tag == req_tag);
        miss        = accept && !hit;
        forward     = beat_we && (beat_word == miss_word_q);
    end

    // Latch the coordinates of a missing fetch for the duration of the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_tag_q  <= '0;
            miss_idx_q  <= '0;
            miss_word_q <= '0;
        end else if (miss) begin
            miss_tag_q  <= req_tag;
            miss_idx_q  <= req_idx;
            miss_word_q <= req_word;
        end
    end

    // Response register shared by the hit path and the miss forward path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            fetch_data  <= '0;
        end else begin
            fetch_valid <= hit || forward;
            if (hit) begin
                fetch_data <= look_data;
            end else if (forward) begin
                fetch_data <= mem_rdata;
            end
        end
    end

    // Burst address is always the base of the missing line.
    assign mem_addr = {miss_tag_q, miss_idx_q, {(WORD_W + BOFF_W){1'b0}}};

    icache_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_all  (inv_all),
        .rd_idx   (req_idx),
        .rd_tag   (look_tag),
        .rd_valid (look_valid),
        .wr_en    (install),
        .wr_idx   (miss_idx_q),
        .wr_tag   (miss_tag_q)
    );

    icache_data_array #(
        .LINES      (LINES),
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (beat_we),
        .wr_idx  (miss_idx_q),
        .wr_word (beat_word),
        .wr_data (mem_rdata),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (look_data)
    );

    icache_fill_ctrl #(
        .LINE_WORDS (LINE_WORDS)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (miss),
        .inv_all    (inv_all),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .busy       (busy),
        .beat_we    (beat_we),
        .beat_word  (beat_word),
        .install    (install)
    );

endmodule

// File: rtl/icache_checker.sv
// Module icache_checker
// Port-level protocol properties of fetch_icache, attached through bind.
// Assumes the synchronous active-low reset of the cache.
module icache_checker #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 512,
    parameter int LINE_WORDS  = 4,
    localparam int LOW_W      = $clog2(DATA_W / 8) + $clog2(LINE_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ready,
    input logic              fetch_valid,
    input logic [DATA_W-1:0] fetch_data,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic [DATA_W-1:0] mem_rdata
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R2

    AST_LINE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LOW_W-1:0] == '0)); // R11

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req); // R11

    AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_ready); // R7

    AST_INV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |-> !fetch_ready); // R8

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($past(fetch_req && fetch_ready) || $past(mem_rvalid))); // R4

endmodule

bind fetch_icache icache_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CACHE_BYTES (CACHE_BYTES),
    .LINE_WORDS  (LINE_WORDS)
) u_chk (.*);

// File: tb/fetch_icache_tb.sv
`timescale 1ns/1ps
// Bench for fetch_icache: a table of fetches with expected hit/miss walked
// by one loop, then directed tests for stalls and invalidation.
module fetch_icache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready;
    logic        fetch_valid;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int grants = 0;
    int vcount = 0;
    int beat_gap = 0;
    int gnt_delay = 0;
    int inv_beat = -1;
    logic [31:0] exp_base = '0;
    int want_word = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fetch_icache u_dut (.*);

    // Table: bit 32 = expected hit, bits 31:0 = fetch address.
    localparam int NVEC = 12;
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 32'h0000_1000}, {1'b1, 32'h0000_1004}, {1'b1, 32'h0000_100C},
        {1'b0, 32'h0000_1018}, {1'b1, 32'h0000_1010}, {1'b1, 32'h0000_1008},
        {1'b0, 32'h0000_1200}, {1'b0, 32'h0000_1000}, {1'b0, 32'h0000_121C},
        {1'b0, 32'h0000_1014}, {1'b0, 32'hFFFF_FFF0}, {1'b1, 32'hFFFF_FFFC}
    };

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Count response pulses.
    always @(negedge clk) if (rst_n && fetch_valid) vcount++;

    // Memory model: grant after a delay, then four beats with gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                check(mem_addr == exp_base, "R2 burst base", mem_addr, exp_base);
                check(mem_addr[3:0] == 4'h0, "R11 aligned", {28'h0, mem_addr[3:0]}, 32'h0);
                for (int d = 0; d < gnt_delay; d++) begin
                    @(negedge clk);
                    check(mem_req == 1'b1, "R2 request held", {31'h0, mem_req}, 32'h1);
                end
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                grants++;
                check(mem_req == 1'b0, "R11 request drops", {31'h0, mem_req}, 32'h0);
                for (int i = 0; i < 4; i++) begin
                    for (int s = 0; s < beat_gap; s++) @(negedge clk);
                    if (i == inv_beat) inv_all = 1'b1;
                    mem_rvalid = 1'b1;
                    mem_rdata = word_of(exp_base + 32'(4 * i));
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                    mem_rdata = '0;
                    inv_all = 1'b0;
                    check(fetch_valid == (i == want_word), "R4 forward cycle",
                          {31'h0, fetch_valid}, {31'h0, (i == want_word)});
                    check(fetch_ready == (i == 3), "R7 ready return",
                          {31'h0, fetch_ready}, {31'h0, (i == 3)});
                end
            end
        end
    end

    task automatic do_fetch(input logic [31:0] a, input bit exp_hit, input string req);
        int g0;
        int waited;
        g0 = grants;
        exp_base = {a[31:4], 4'h0};
        want_word = int'(a[3:2]);
        @(negedge clk);
        vcount = 0;
        fetch_addr = a;
        fetch_req = 1'b1;
        while (!fetch_ready) @(negedge clk);
        @(negedge clk);
        fetch_req = 1'b0;
        if (exp_hit) begin
            check(fetch_valid == 1'b1, {req, " hit next cycle"}, {31'h0, fetch_valid}, 32'h1);
        end else begin
            waited = 0;
            while (!fetch_valid && waited < 200) begin
                @(negedge clk);
                waited++;
            end
        end
        check(fetch_data == word_of(a), {req, " data"}, fetch_data, word_of(a));
        waited = 0;
        while (!fetch_ready && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        check(vcount == 1, "R4 single response", 32'(vcount), 32'h1);
        check((grants - g0) == (exp_hit ? 0 : 1), {req, " hit/miss"},
              32'(grants - g0), exp_hit ? 32'h0 : 32'h1);
    endtask

    // Watchdog.
    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fetch_ready == 1'b1, "R1 ready", {31'h0, fetch_ready}, 32'h1);
        check(fetch_valid == 1'b0, "R1 valid", {31'h0, fetch_valid}, 32'h0);
        check(mem_req == 1'b0, "R1 mem_req", {31'h0, mem_req}, 32'h0);

        // Table walk: R1 first miss, R3 hits, R5 word order, R10 eviction.
        for (int v = 0; v < NVEC; v++) begin
            gnt_delay = v % 3;
            beat_gap = (v % 4 == 3) ? 2 : 0;
            do_fetch(VEC[v][31:0], VEC[v][32], "R3/R5/R10 table");
        end

        // R6: long gaps between beats, request last word, then hit the rest.
        beat_gap = 3;
        gnt_delay = 1;
        do_fetch(32'h0000_204C, 1'b0, "R6 stalled fill");
        beat_gap = 0;
        do_fetch(32'h0000_2040, 1'b1, "R6 word0");
        do_fetch(32'h0000_2044, 1'b1, "R6 word1");
        do_fetch(32'h0000_2048, 1'b1, "R6 word2");

        // R8: invalidate-all clears filled lines.
        do_fetch(32'h0000_3000, 1'b0, "R8 fill a");
        do_fetch(32'h0000_3010, 1'b0, "R8 fill b");
        @(negedge clk);
        inv_all = 1'b1;
        #1;
        check(fetch_ready == 1'b0, "R8 ready low", {31'h0, fetch_ready}, 32'h0);
        @(negedge clk);
        inv_all = 1'b0;
        do_fetch(32'h0000_3004, 1'b0, "R8 after inv a");
        do_fetch(32'h0000_3018, 1'b0, "R8 after inv b");

        // R9: invalidate during a fill leaves the line invalid.
        inv_beat = 1;
        do_fetch(32'h0000_4028, 1'b0, "R9 poisoned fill");
        inv_beat = -1;
        do_fetch(32'h0000_4028, 1'b0, "R9 refetch misses");
        do_fetch(32'h0000_4020, 1'b1, "R9 then hits");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule